// File: doc/BRIEF.md
# Integer ALU with Class-Steered Operation Decoder

This block is the arithmetic core of a simple integer datapath. It combines a small two-level decoder with a 32-bit arithmetic/logic unit. The main controller supplies a 2-bit operation class. The instruction supplies a 6-bit function field. From these two inputs the decoder chooses a 3-bit operation code. Depending on the class, that code is a fixed add (for address arithmetic), a fixed subtract (for equality compares), or an operation decoded from the function field.

The unit applies the chosen operation to two operands and produces four things: the result, a flag that is set when the result is all zeros, a signed overflow flag that can feed an exception path, and a flag that marks an unrecognised function field. The block is purely combinational and holds no state.

Top module: `alu_decode_unit`

## Requirements
- R1: With class 00 the operation code is 010 (add) for every function field.
- R2: With class 01 the operation code is 110 (subtract) for every function field.
- R3: With class 10 the function field selects the operation: 100000 gives 010 add, 100010 gives 110 subtract, 100100 gives 000 AND, 100101 gives 001 OR, and 101010 gives 111 set-less-than.
- R4: With class 10 and any other function field, the operation falls back to 010 (add) and the illegal-function flag is 1. In every other case that flag is 0.
- R5: Class 11 is reserved. It gives 010 (add) and does not raise the illegal-function flag.
- R6: The result is the bitwise AND, the bitwise OR, the sum modulo 2^32, or the difference modulo 2^32 of the operands, as the operation code selects.
- R7: Set-less-than treats both operands as signed two's-complement numbers. It returns 1 in bit 0, with all other bits 0, exactly when A < B. The answer stays correct when A - B overflows.
- R8: The zero flag is 1 exactly when all 32 result bits are 0.
- R9: The overflow flag is 1 only for add or subtract, and only when the true signed result does not fit in 32 bits. For AND, OR and set-less-than it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller |
| fn_code | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_op | output | 3 | Operation code chosen by the decoder |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow on add or subtract |
| illegal_fn | output | 1 | Unrecognised function field under class 10 |

## Verification
The checker evaluates its properties whenever an input changes. It therefore assumes that every input is a defined two-state value and that the inputs of one vector are applied together. The bench meets this by driving all four inputs in a single step and sampling only after a settling delay.

The random stimulus draws the function field mostly from the five legal codes and only sometimes at random. This keeps the illegal path exercised without starving the legal ones. Operands are biased toward the sign boundaries and toward equal values, so that overflow, set-less-than under overflow and a zero result all occur often.

// File: rtl/alu_decode_unit.sv
module alu_decode_unit #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_class,
  input  logic [5:0]       fn_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [2:0]       alu_op,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf,
  output logic             illegal_fn
);
  localparam int MSB = WIDTH - 1;

  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic [2:0] fn_op;
  logic       fn_bad;

  always_comb begin
    fn_bad = 1'b0;
    case (fn_code)
      6'b100000: fn_op = OP_ADD;
      6'b100010: fn_op = OP_SUB;
      6'b100100: fn_op = OP_AND;
      6'b100101: fn_op = OP_OR;
      6'b101010: fn_op = OP_SLT;
      default: begin
        fn_op  = OP_ADD;
        fn_bad = 1'b1;
      end
    endcase
  end

  always_comb begin
    case (op_class)
      2'b01:   alu_op = OP_SUB;
      2'b10:   alu_op = fn_op;
      default: alu_op = OP_ADD;
    endcase
  end

  assign illegal_fn = (op_class == 2'b10) & fn_bad;

  logic [WIDTH-1:0] sum, diff;
  logic             add_v, sub_v, lt;

  assign sum   = opnd_a + opnd_b;
  assign diff  = opnd_a - opnd_b;
  assign add_v = (opnd_a[MSB] == opnd_b[MSB]) & (sum[MSB] != opnd_a[MSB]);
  assign sub_v = (opnd_a[MSB] != opnd_b[MSB]) & (diff[MSB] != opnd_a[MSB]);
  assign lt    = diff[MSB] ^ sub_v;

  always_comb begin
    case (alu_op)
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt};
      default: result = '0;
    endcase
  end

  assign ovf  = ((alu_op == OP_ADD) & add_v) | ((alu_op == OP_SUB) & sub_v);
  assign zero = ~|result;
endmodule

// File: rtl/alu_decode_chk.sv
module alu_decode_chk #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       op_class,
  input logic [5:0]       fn_code,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       alu_op,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             ovf,
  input logic             illegal_fn
);
  always_comb begin
    AST_CLASS_ADD: assert (op_class != 2'b00 || alu_op == 3'b010); // R1
    AST_CLASS_SUB: assert (op_class != 2'b01 || alu_op == 3'b110); // R2
    AST_ILLEGAL_ADD: assert (!illegal_fn || (op_class == 2'b10 && alu_op == 3'b010)); // R4
    AST_RESERVED_CLASS: assert (op_class != 2'b11 || (alu_op == 3'b010 && !illegal_fn)); // R5
    AST_SLT_BIT: assert (alu_op != 3'b111 || result[WIDTH-1:1] == '0); // R7
    AST_ZERO_FLAG: assert (zero == (result == '0)); // R8
    AST_NO_OVERFLOW: assert (!ovf || alu_op == 3'b010 || alu_op == 3'b110); // R9
    AST_EQUAL_SUB: assert (!(alu_op == 3'b110 && opnd_a == opnd_b) || (zero && !ovf)); // R8
  end
endmodule

bind alu_decode_unit alu_decode_chk #(.WIDTH(WIDTH)) u_chk (
  .op_class(op_class), .fn_code(fn_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .alu_op(alu_op), .result(result), .zero(zero), .ovf(ovf), .illegal_fn(illegal_fn)
);

// File: tb/alu_decode_unit_tb.sv
module alu_decode_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [1:0]  op_class;
  logic [5:0]  fn_code;
  logic [31:0] opnd_a, opnd_b;
  logic [2:0]  alu_op;
  logic [31:0] result;
  logic        zero, ovf, illegal_fn;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_decode_unit u_dut (
    .op_class(op_class), .fn_code(fn_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_op(alu_op), .result(result), .zero(zero), .ovf(ovf), .illegal_fn(illegal_fn)
  );

  function automatic logic [2:0] ref_op(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b01) return 3'b110;
    if (c != 2'b10) return 3'b010;
    if (f == 6'h20) return 3'b010;
    if (f == 6'h22) return 3'b110;
    if (f == 6'h24) return 3'b000;
    if (f == 6'h25) return 3'b001;
    if (f == 6'h2a) return 3'b111;
    return 3'b010;
  endfunction

  function automatic logic ref_ill(input logic [1:0] c, input logic [5:0] f);
    return c == 2'b10 && !(f == 6'h20 || f == 6'h22 || f == 6'h24 || f == 6'h25 || f == 6'h2a);
  endfunction

  function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    case (op)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return 32'(sa + sb);
      3'b110:  return 32'(sa - sb);
      3'b111:  return (sa < sb) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint t;
    if (op == 3'b010) t = sa + sb;
    else if (op == 3'b110) t = sa - sb;
    else return 1'b0;
    return t > 64'sd2147483647 || t < -64'sd2147483648;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cls=%b fn=%b a=%h b=%h actual=%h expected=%h",
               req, op_class, fn_code, opnd_a, opnd_b, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    logic [2:0]  eop;
    logic [31:0] eres;
    op_class = c; fn_code = f; opnd_a = a; opnd_b = b;
    #(CLK_PERIOD/2);
    eop  = ref_op(c, f);
    eres = ref_res(eop, a, b);
    chk((c == 2'b00) ? "R1 op" : (c == 2'b01) ? "R2 op" : (c == 2'b10) ? "R3 op" : "R5 op",
        32'(alu_op), 32'(eop));
    chk("R4 illegal", 32'(illegal_fn), 32'(ref_ill(c, f)));
    chk((eop == 3'b111) ? "R7 slt" : "R6 result", result, eres);
    chk("R8 zero", 32'(zero), 32'(eres == 32'd0));
    chk("R9 ovf", 32'(ovf), 32'(ref_ovf(eop, a, b)));
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000 + $urandom_range(0, 3);
      1: return 32'h7fff_ffff - $urandom_range(0, 3);
      2: return $urandom_range(0, 2);
      3: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [5:0] legal [5];
    void'($urandom(32'd1234));
    legal[0] = 6'h20; legal[1] = 6'h22; legal[2] = 6'h24; legal[3] = 6'h25; legal[4] = 6'h2a;

    // idle state: all inputs zero, add of zeros gives zero flag
    apply(2'b00, 6'h00, 32'd0, 32'd0);
    // R1: forced add ignores the function field
    apply(2'b00, 6'h24, 32'h0000_0010, 32'hffff_fffc);
    apply(2'b00, 6'h2a, 32'h7fff_ffff, 32'd1);
    // R2: forced subtract, equality compare sets zero
    apply(2'b01, 6'h25, 32'h1234_5678, 32'h1234_5678);
    apply(2'b01, 6'h00, 32'h8000_0000, 32'd1);
    // R3 decode of each legal code
    for (int i = 0; i < 5; i++) apply(2'b10, legal[i], 32'hf0f0_1234, 32'h0ff0_4321);
    // R4 illegal codes
    apply(2'b10, 6'h3f, 32'd5, 32'd7);
    apply(2'b10, 6'h21, 32'hffff_ffff, 32'd1);
    // R5 reserved class
    apply(2'b11, 6'h3f, 32'd9, 32'd3);
    // R7 slt under subtract overflow and across signs
    apply(2'b10, 6'h2a, 32'h8000_0000, 32'h0000_0001);
    apply(2'b10, 6'h2a, 32'h7fff_ffff, 32'hffff_ffff);
    apply(2'b10, 6'h2a, 32'hffff_ffff, 32'h0000_0000);
    apply(2'b10, 6'h2a, 32'd4, 32'd4);
    // R9 overflow boundaries and suppression on logic ops
    apply(2'b10, 6'h20, 32'h8000_0000, 32'h8000_0000);
    apply(2'b10, 6'h22, 32'h7fff_ffff, 32'hffff_ffff);
    apply(2'b10, 6'h24, 32'h8000_0000, 32'h8000_0000);
    apply(2'b10, 6'h25, 32'h0, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  c;
      logic [5:0]  f;
      logic [31:0] a, b;
      c = 2'($urandom_range(0, 3));
      f = ($urandom_range(0, 4) == 0) ? 6'($urandom) : legal[$urandom_range(0, 4)];
      a = pick_val();
      b = ($urandom_range(0, 7) == 0) ? a : pick_val();
      apply(c, f, a, b);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule